// File: doc/BRIEF.md
# Parallel Vector Dot-Product Unit

The unit forms the inner product of a snapshot vector of signed samples with a set of signed weights held inside the block. All sample lanes arrive together in one cycle on a single wide bus. Nothing is kept from earlier cycles, so this is not a filter with a tapped delay line. Each lane is multiplied by its weight in a registered multiplier stage. A registered binary adder tree then reduces the products to one sum at full precision, with no rounding and no saturation.

Weights can be changed at run time through a small write port that carries an index, a value and an enable. A strobe accompanies each vector and comes out on the result side after a fixed number of cycles. A new vector may enter on every cycle. With the default of 15 lanes, the tree is padded to 16 leaves, which gives four adder levels and a latency of five cycles.

Top module: `dot_engine`

## Requirements
- R1: When `out_valid` is high, `out_sum` equals the sum over all lanes i of weight[i] times sample[i]. All values are two's complement. The sum is exact at a width of DW+CW+ceil(log2 LANES) bits (28 bits by default).
- R2: Lane i of `in_vec` occupies bits [i*DW +: DW] and is paired only with weight i.
- R3: Each cycle in which `in_valid` is high yields exactly one cycle of `out_valid`, ceil(log2 LANES)+1 cycles later (5 by default). Vectors on consecutive cycles give results on consecutive cycles.
- R4: `out_valid` stays low in every cycle that does not correspond to an accepted vector.
- R5: A cycle with `cw_en` high and `cw_idx` below LANES stores `cw_data`, read as a signed CW-bit value, as weight number `cw_idx`.
- R6: A weight write is used by vectors accepted in later cycles. A vector accepted in the same cycle as the write still uses the previous weight.
- R7: A write with `cw_idx` at LANES or above (the value 15 by default) changes no weight.
- R8: A synchronous active-high reset discards every vector in flight, so `out_valid` is low in the cycle after reset and stays low until a new vector has passed through. Reset also sets all weights to zero.
- R9: Extreme operands do not overflow. With every sample and every weight at -2048, the result is 62914560. With samples at 2047 and weights at -2048, the result is -62883840.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The vector on `in_vec` is accepted this cycle |
| in_vec | input | LANES*DW | Packed signed samples, lane i at bits [i*DW +: DW] |
| cw_en | input | 1 | Weight write enable |
| cw_idx | input | ceil(log2 LANES) | Index of the weight to write |
| cw_data | input | CW | Signed weight value |
| out_valid | output | 1 | `out_sum` holds a result |
| out_sum | output | DW+CW+ceil(log2 LANES) | Signed inner product |

## Verification
A weight write and the acceptance of a vector can fall in the same cycle, and the result depends on which weight that vector sees. The bench provokes this by writing a new value to one lane while presenting a vector in the same cycle. It then presents the identical vector in the next cycle. The first result must use the old weight and the second the new one, and the two results must differ by exactly that lane's sample times the change in weight.

// File: rtl/dot_engine.sv
`timescale 1ns/1ps
module dot_engine #(
  parameter int LANES = 15,
  parameter int DW = 12,
  parameter int CW = 12,
  localparam int LVL = $clog2(LANES),
  localparam int IW = LVL,
  localparam int RW = DW + CW + LVL
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] in_vec,
  input  logic                cw_en,
  input  logic [IW-1:0]       cw_idx,
  input  logic [CW-1:0]       cw_data,
  output logic                out_valid,
  output logic [RW-1:0]       out_sum
);
  localparam int P2 = 1 << LVL;
  localparam int NN = 2 * P2 - 1;

  logic signed [CW-1:0] coef [LANES];
  logic signed [RW-1:0] prod [P2];
  logic signed [RW-1:0] node [NN];
  logic [LVL:0] vpipe;

  generate
    for (genvar i = 0; i < P2; i++) begin : g_lane
      if (i < LANES) begin : g_mul
        assign prod[i] = RW'($signed(in_vec[i*DW +: DW])) * RW'(coef[i]);
      end else begin : g_pad
        assign prod[i] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LANES; k++) coef[k] <= '0;
    end else if (cw_en && (int'(cw_idx) < LANES)) begin
      coef[cw_idx] <= cw_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < P2 - 1; k++) node[k] <= node[2*k+1] + node[2*k+2];
    for (int k = 0; k < P2; k++) node[P2-1+k] <= prod[k];
  end

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LVL-1:0], in_valid};
  end

  assign out_valid = vpipe[LVL];
  assign out_sum   = node[0];
endmodule

// File: rtl/dot_engine_chk.sv
`timescale 1ns/1ps
module dot_engine_chk #(
  parameter int LANES = 15,
  parameter int DW = 12,
  parameter int CW = 12,
  localparam int LVL = $clog2(LANES),
  localparam int RW = DW + CW + LVL
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [RW-1:0] out_sum
);
  localparam int LAT = LVL + 1;
  localparam longint BOUND = longint'(LANES) << (DW + CW - 2);

  logic [$clog2(LAT+1):0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (int'(age) < LAT) age <= age + 1'b1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(age) >= LAT) |-> (out_valid == $past(in_valid, LAT)));

  // R8
  idle_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(age) < LAT) |-> !out_valid);

  // R8
  flush_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R9
  range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (($signed(out_sum) <= BOUND) && ($signed(out_sum) >= -BOUND)));
endmodule

bind dot_engine dot_engine_chk #(.LANES(LANES), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/test_dot_engine.sv
`timescale 1ns/1ps
module test_dot_engine;
  localparam int LN = 15;
  localparam int DW = 12;
  localparam int CW = 12;
  localparam int LAT = 5;
  localparam int RW = 28;
  localparam int VW = LN * DW;

  localparam int TBL [6][4] = '{
    '{1, 1, 1, 0},
    '{-3, 7, 5, -2},
    '{100, -37, -200, 29},
    '{2047, -1, -2048, 1},
    '{-2048, 0, -2048, 0},
    '{0, 0, 0, 0}
  };

  logic clk = 0, rst = 1, in_valid = 0, cw_en = 0;
  logic [VW-1:0] in_vec = '0;
  logic [3:0] cw_idx = '0;
  logic [CW-1:0] cw_data = '0;
  logic out_valid;
  logic [RW-1:0] out_sum;

  int total = 0, bad = 0;
  bit done = 0;
  longint mcoef [LN];
  bit mv [LAT];
  longint ms [LAT];
  string mr [LAT];

  always #4 clk = ~clk;

  dot_engine i_dot_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  function automatic longint sext(int d);
    logic [11:0] t = 12'(d);
    return longint'($signed(t));
  endfunction

  function automatic longint dotm(logic [VW-1:0] v);
    longint s = 0;
    for (int i = 0; i < LN; i++) s += longint'($signed(v[i*DW +: DW])) * mcoef[i];
    return s;
  endfunction

  function automatic logic [VW-1:0] mkvec(int b, int s);
    logic [VW-1:0] v;
    for (int i = 0; i < LN; i++) v[i*DW +: DW] = DW'(b + i * s);
    return v;
  endfunction

  task automatic clear_model();
    for (int k = 0; k < LAT; k++) begin mv[k] = 0; ms[k] = 0; mr[k] = "R4"; end
    for (int k = 0; k < LN; k++) mcoef[k] = 0;
  endtask

  task automatic check(string req, bit ev, longint es);
    total++;
    if (out_valid !== ev) begin
      bad++;
      $display("FAIL %s out_valid act=%0b exp=%0b", req, out_valid, ev);
    end else if (ev && longint'($signed(out_sum)) != es) begin
      bad++;
      $display("FAIL %s out_sum act=%0d exp=%0d", req, longint'($signed(out_sum)), es);
    end
  endtask

  task automatic step(bit v, logic [VW-1:0] vec, bit we, int idx, int data, string req);
    in_valid = v; in_vec = vec; cw_en = we; cw_idx = 4'(idx); cw_data = CW'(data);
    for (int k = LAT - 1; k > 0; k--) begin mv[k] = mv[k-1]; ms[k] = ms[k-1]; mr[k] = mr[k-1]; end
    mv[0] = v; ms[0] = dotm(vec); mr[0] = v ? req : "R4";
    if (we && idx >= 0 && idx < LN) mcoef[idx] = sext(data);
    @(posedge clk); @(negedge clk);
    check(mr[LAT-1], mv[LAT-1], ms[LAT-1]);
  endtask

  task automatic drain();
    for (int k = 0; k < LAT + 1; k++) step(0, '0, 0, 0, 0, "R4");
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; cw_en = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    clear_model();
    check("R8", 0, 0);
  endtask

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R8", 0, 0);
    step(1, mkvec(5, 3), 0, 0, 0, "R8");
    drain();

    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < LN; i++) step(0, '0, 1, i, TBL[r][2] + i * TBL[r][3], "R5");
      step(1, mkvec(TBL[r][0], TBL[r][1]), 0, 0, 0, "R1");
    end
    drain();

    for (int i = 0; i < LN; i++) step(0, '0, 1, i, i + 1, "R5");
    for (int l = 0; l < LN; l += 7) begin
      logic [VW-1:0] v = '0;
      v[l*DW +: DW] = DW'(-5);
      step(1, v, 0, 0, 0, "R2");
    end
    drain();

    for (int j = 0; j < 10; j++) step(1, mkvec(j, 2 * j - 7), 0, 0, 0, "R3");
    drain();

    step(1, mkvec(3, 1), 1, 3, -700, "R6");
    step(1, mkvec(3, 1), 0, 0, 0, "R6");
    step(1, mkvec(-9, 4), 1, 0, 1999, "R6");
    step(1, mkvec(-9, 4), 0, 0, 0, "R6");
    drain();

    step(0, '0, 1, 15, 1234, "R7");
    step(1, mkvec(10, 11), 0, 0, 0, "R7");
    drain();

    for (int i = 0; i < LN; i++) step(0, '0, 1, i, -2048, "R5");
    step(1, mkvec(-2048, 0), 0, 0, 0, "R9");
    step(1, mkvec(2047, 0), 0, 0, 0, "R9");
    drain();

    step(1, mkvec(1, 2), 0, 0, 0, "R8");
    step(1, mkvec(4, -1), 0, 0, 0, "R8");
    do_reset();
    for (int k = 0; k < LAT; k++) step(0, '0, 0, 0, 0, "R8");
    step(1, mkvec(77, -5), 0, 0, 0, "R8");
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule